// File: doc/BRIEF.md
# Single-Bus Hardwired Step Controller

This block sequences a processor built around one internal bus. A one-hot step counter walks through the time slots of an instruction. Combinational logic turns the current slot and the decoded opcode into the gating lines of the datapath. Each gating line is a sum of products of step bits and decoded instruction lines. The gating lines control the bus drivers and loads of PC, IR, Y, Z, MAR, MDR, the source and destination registers and the branch offset field. They also drive the memory read strobe, the ALU add command and the ALU input select, which picks either the constant four or Y.

Every instruction begins with the same three-step fetch. The execute phase depends on the opcode. An unconditional branch adds the IR offset to the incremented PC held in Y. A register add fetches a memory operand addressed by the source register and adds it to the destination register. Any other opcode ends at once. Steps that must wait for memory raise a wait request. While that request is raised and memory has not yet reported completion, the counter holds its value. The instruction-done line sends the counter back to the first step on the next clock.

Top module: `sbus_step_ctrl`

## Requirements
- R1: A synchronous reset puts the 7-bit one-hot step output at T1 (bit 0 set). Step k is bit k-1. Exactly one step bit is set at all times after reset.
- R2: In T1 the outputs are exactly pc_out, mar_in, mem_read, sel_four, alu_add and z_load. All other outputs are low.
- R3: In T2 the outputs are exactly z_drive, pc_in, y_load and wait_mfc.
- R4: When wait_mfc is high and mfc is low, the step holds across the clock. It advances on the first clock at which mfc is high. In steps that do not raise wait_mfc, mfc has no effect.
- R5: In T3 the outputs are exactly mdr_drive and ir_load.
- R6: With opcode 4'b0010 (branch), T4 gives offset_drive, alu_add and z_load. T5 gives z_drive, pc_in and done.
- R7: With opcode 4'b0001 (add), the execute steps are as follows. T4 gives src_drive, mar_in and mem_read. T5 gives dst_drive, y_load and wait_mfc. T6 gives mdr_drive, alu_add and z_load, with sel_four low. T7 gives z_drive, dst_load and done.
- R8: When done is high, the step is T1 after the next clock.
- R9: Any opcode other than 4'b0001 or 4'b0010 raises only done in T4.
- R10: The opcode input has no effect on the outputs during T1, T2 and T3.
- R11: At most one of the bus drivers is active in any step. The drivers are pc_out, z_drive, mdr_drive, offset_drive, src_drive and dst_drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Opcode field of IR |
| mfc | input | 1 | Memory function complete |
| step | output | 7 | One-hot current step |
| pc_out | output | 1 | PC drives the bus |
| pc_in | output | 1 | PC loads from the bus |
| mar_in | output | 1 | MAR loads from the bus |
| mem_read | output | 1 | Memory read request |
| sel_four | output | 1 | ALU input A = constant 4 (else Y) |
| alu_add | output | 1 | ALU add command |
| z_load | output | 1 | Z loads the ALU result |
| z_drive | output | 1 | Z drives the bus |
| y_load | output | 1 | Y loads from the bus |
| mdr_drive | output | 1 | MDR drives the bus |
| ir_load | output | 1 | IR loads from the bus |
| offset_drive | output | 1 | IR offset field drives the bus |
| src_drive | output | 1 | Source register drives the bus |
| dst_drive | output | 1 | Destination register drives the bus |
| dst_load | output | 1 | Destination register loads from the bus |
| wait_mfc | output | 1 | Wait for memory completion |
| done | output | 1 | Instruction end, restart at T1 |

## Verification
Two things can fall in the same clock: a memory completion and the end of a wait step. mfc can rise in the very first cycle of T2 or of the add's T5, which must advance the counter with no stall. It can also rise several cycles later, which must give an exact number of repeated control words. The stimulus mixes zero, one, two and three cycles of memory latency, and it drives noise on mfc in the steps that do not wait. A behavioural model counts steps as an integer and predicts the full 17-bit control word and the one-hot step every cycle. A reset applied during a stall must also win over the held count.

// File: rtl/step_ctl_pkg.sv
package step_ctl_pkg;

    localparam int NSTEPS = 7;

    typedef enum logic [NSTEPS-1:0] {
        T1 = 7'b0000001,
        T2 = 7'b0000010,
        T3 = 7'b0000100,
        T4 = 7'b0001000,
        T5 = 7'b0010000,
        T6 = 7'b0100000,
        T7 = 7'b1000000
    } step_e;

    typedef struct packed {
        logic is_add;
        logic is_br;
        logic is_other;
    } ins_t;

    typedef struct packed {
        logic pc_out;
        logic pc_in;
        logic mar_in;
        logic mem_read;
        logic sel_four;
        logic alu_add;
        logic z_load;
        logic z_drive;
        logic y_load;
        logic mdr_drive;
        logic ir_load;
        logic offset_drive;
        logic src_drive;
        logic dst_drive;
        logic dst_load;
        logic wait_mfc;
        logic done;
    } ctl_t;

endpackage

// File: rtl/step_counter.sv
module step_counter
    import step_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  done,
    input  logic  wait_mfc,
    input  logic  mfc,
    output step_e step
);

    step_e nxt;

    always_ff @(posedge clk) begin
        if (rst) step <= T1;
        else     step <= nxt;
    end

    always_comb begin
        nxt = step;
        if (done) begin
            nxt = T1;
        end else if (wait_mfc && !mfc) begin
            nxt = step;
        end else begin
            unique case (step)
                T1:      nxt = T2;
                T2:      nxt = T3;
                T3:      nxt = T4;
                T4:      nxt = T5;
                T5:      nxt = T6;
                T6:      nxt = T7;
                T7:      nxt = T1;
                default: nxt = T1;
            endcase
        end
    end

    // R1
    onehot_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(step) == 1);

    // R1
    reset_to_t1_chk: assert property (@(posedge clk)
        rst |=> step == T1);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_mfc && !mfc && !done) |=> $stable(step));

    // R8
    done_restart_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> step == T1);

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import step_ctl_pkg::*;
#(
    parameter int               OPC_W   = 4,
    parameter logic [OPC_W-1:0] OPC_ADD = 4'b0001,
    parameter logic [OPC_W-1:0] OPC_BR  = 4'b0010
) (
    input  logic [OPC_W-1:0] opcode,
    output ins_t             ins
);

    always_comb begin
        ins          = '0;
        ins.is_add   = (opcode == OPC_ADD);
        ins.is_br    = (opcode == OPC_BR);
        ins.is_other = !(ins.is_add || ins.is_br);
    end

endmodule

// File: rtl/ctl_encoder.sv
module ctl_encoder
    import step_ctl_pkg::*;
(
    input  step_e step,
    input  ins_t  ins,
    output ctl_t  ctl
);

    logic t1, t2, t3, t4, t5, t6, t7;

    always_comb begin
        {t7, t6, t5, t4, t3, t2, t1} = step;

        ctl              = '0;
        ctl.pc_out       = t1;
        ctl.pc_in        = t2 | (t5 & ins.is_br);
        ctl.mar_in       = t1 | (t4 & ins.is_add);
        ctl.mem_read     = t1 | (t4 & ins.is_add);
        ctl.sel_four     = t1;
        ctl.alu_add      = t1 | (t4 & ins.is_br) | (t6 & ins.is_add);
        ctl.z_load       = t1 | (t4 & ins.is_br) | (t6 & ins.is_add);
        ctl.z_drive      = t2 | (t5 & ins.is_br) | (t7 & ins.is_add);
        ctl.y_load       = t2 | (t5 & ins.is_add);
        ctl.mdr_drive    = t3 | (t6 & ins.is_add);
        ctl.ir_load      = t3;
        ctl.offset_drive = t4 & ins.is_br;
        ctl.src_drive    = t4 & ins.is_add;
        ctl.dst_drive    = t5 & ins.is_add;
        ctl.dst_load     = t7 & ins.is_add;
        ctl.wait_mfc     = t2 | (t5 & ins.is_add);
        ctl.done         = (t5 & ins.is_br) | (t7 & ins.is_add) |
                           (t4 & ins.is_other);
    end

endmodule

// File: rtl/sbus_step_ctrl.sv
module sbus_step_ctrl
    import step_ctl_pkg::*;
#(
    parameter int               OPC_W   = 4,
    parameter logic [OPC_W-1:0] OPC_ADD = 4'b0001,
    parameter logic [OPC_W-1:0] OPC_BR  = 4'b0010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              mfc,
    output logic [NSTEPS-1:0] step,
    output logic              pc_out,
    output logic              pc_in,
    output logic              mar_in,
    output logic              mem_read,
    output logic              sel_four,
    output logic              alu_add,
    output logic              z_load,
    output logic              z_drive,
    output logic              y_load,
    output logic              mdr_drive,
    output logic              ir_load,
    output logic              offset_drive,
    output logic              src_drive,
    output logic              dst_drive,
    output logic              dst_load,
    output logic              wait_mfc,
    output logic              done
);

    step_e cur;
    ins_t  ins;
    ctl_t  ctl;

    step_counter u_ctr (
        .clk      (clk),
        .rst      (rst),
        .done     (ctl.done),
        .wait_mfc (ctl.wait_mfc),
        .mfc      (mfc),
        .step     (cur)
    );

    instr_decoder #(
        .OPC_W   (OPC_W),
        .OPC_ADD (OPC_ADD),
        .OPC_BR  (OPC_BR)
    ) u_dec (
        .opcode (opcode),
        .ins    (ins)
    );

    ctl_encoder u_enc (
        .step (cur),
        .ins  (ins),
        .ctl  (ctl)
    );

    assign step = cur;
    assign {pc_out, pc_in, mar_in, mem_read, sel_four, alu_add, z_load,
            z_drive, y_load, mdr_drive, ir_load, offset_drive, src_drive,
            dst_drive, dst_load, wait_mfc, done} = ctl;

    // R11
    one_bus_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({pc_out, z_drive, mdr_drive, offset_drive,
                    src_drive, dst_drive}) <= 1);

    // R6
    branch_sum_chk: assert property (@(posedge clk) disable iff (rst)
        offset_drive |=> (pc_in && z_drive && done));

endmodule

// File: tb/sbus_step_ctrl_test.sv
module sbus_step_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NPROG      = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode = 4'h0;
    logic       mfc = 1'b0;
    logic [6:0] step;
    logic pc_out, pc_in, mar_in, mem_read, sel_four, alu_add, z_load;
    logic z_drive, y_load, mdr_drive, ir_load, offset_drive, src_drive;
    logic dst_drive, dst_load, wait_mfc, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbus_step_ctrl uut (
        .clk(clk), .rst(rst), .opcode(opcode), .mfc(mfc), .step(step),
        .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in),
        .mem_read(mem_read), .sel_four(sel_four), .alu_add(alu_add),
        .z_load(z_load), .z_drive(z_drive), .y_load(y_load),
        .mdr_drive(mdr_drive), .ir_load(ir_load),
        .offset_drive(offset_drive), .src_drive(src_drive),
        .dst_drive(dst_drive), .dst_load(dst_load),
        .wait_mfc(wait_mfc), .done(done)
    );

    // word bit positions
    localparam int B_PCO = 16, B_PCI = 15, B_MAR = 14, B_RD = 13;
    localparam int B_S4 = 12, B_ADD = 11, B_ZI = 10, B_ZO = 9, B_YI = 8;
    localparam int B_MDR = 7, B_IR = 6, B_OFF = 5, B_SRC = 4, B_DO = 3;
    localparam int B_DI = 2, B_WT = 1, B_DN = 0;

    function automatic logic [16:0] exp_word(int st, logic [3:0] opc);
        logic [16:0] w = '0;
        bit is_add = (opc == 4'b0001);
        bit is_br  = (opc == 4'b0010);
        case (st)
            1: begin w[B_PCO]=1; w[B_MAR]=1; w[B_RD]=1; w[B_S4]=1; w[B_ADD]=1; w[B_ZI]=1; end
            2: begin w[B_ZO]=1; w[B_PCI]=1; w[B_YI]=1; w[B_WT]=1; end
            3: begin w[B_MDR]=1; w[B_IR]=1; end
            4: if (is_br) begin w[B_OFF]=1; w[B_ADD]=1; w[B_ZI]=1; end
               else if (is_add) begin w[B_SRC]=1; w[B_MAR]=1; w[B_RD]=1; end
               else w[B_DN]=1;
            5: if (is_br) begin w[B_ZO]=1; w[B_PCI]=1; w[B_DN]=1; end
               else if (is_add) begin w[B_DO]=1; w[B_YI]=1; w[B_WT]=1; end
            6: if (is_add) begin w[B_MDR]=1; w[B_ADD]=1; w[B_ZI]=1; end
            7: if (is_add) begin w[B_ZO]=1; w[B_DI]=1; w[B_DN]=1; end
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic string tag_of(int st, logic [3:0] opc);
        if (st == 1) return "R2 R10";
        if (st == 2) return "R3 R4 R10";
        if (st == 3) return "R5 R10";
        if (opc == 4'b0010) return "R6";
        if (opc == 4'b0001) return "R7 R4";
        return "R9";
    endfunction

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // cycle-by-cycle reference model and comparison
    initial begin
        int st = 1;
        bit prev_rst = 1'b1;
        forever begin
            logic [16:0] obs, exp;
            @(negedge clk);
            #(CLK_PERIOD/4);
            obs = {pc_out, pc_in, mar_in, mem_read, sel_four, alu_add, z_load,
                   z_drive, y_load, mdr_drive, ir_load, offset_drive, src_drive,
                   dst_drive, dst_load, wait_mfc, done};
            exp = exp_word(st, opcode);
            checks++;
            if (step !== 7'(1 << (st - 1))) begin
                fails++;
                $display("FAIL %s step: actual %b expected %b",
                         prev_rst ? "R1" : "R1 R4 R8", step, 7'(1 << (st - 1)));
            end
            checks++;
            if (obs !== exp) begin
                fails++;
                $display("FAIL %s word at T%0d op %h: actual %b expected %b",
                         tag_of(st, opcode), st, opcode, obs, exp);
            end
            checks++;
            if ($countones({pc_out, z_drive, mdr_drive, offset_drive,
                            src_drive, dst_drive}) > 1) begin
                fails++;
                $display("FAIL R11 bus drivers: actual %b expected at most one",
                         {pc_out, z_drive, mdr_drive, offset_drive, src_drive, dst_drive});
            end
            prev_rst = rst;
            if (rst) st = 1;
            else if (exp[B_DN]) st = 1;
            else if (exp[B_WT] && !mfc) st = st;
            else st = (st == 7) ? 1 : st + 1;
        end
    end

    // stimulus
    initial begin
        logic [3:0] prog_opc [NPROG] = '{4'b0010, 4'b0001, 4'b0001, 4'b0010, 4'b0111,
                                         4'b0001, 4'b0000, 4'b0010, 4'b1111, 4'b0001};
        int prog_lat [NPROG] = '{0, 0, 3, 2, 1, 1, 0, 1, 2, 2};
        int idx = 0;
        int wcnt = 0;
        int cyc = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        while (idx < NPROG) begin
            @(negedge clk);
            cyc++;
            if (step[0] || step[1]) opcode = 4'((cyc * 7) ^ 3);
            if (step[2]) opcode = prog_opc[idx];
            if (wait_mfc) begin
                mfc = (wcnt >= prog_lat[idx]);
                wcnt++;
            end else begin
                mfc = cyc[0] ^ cyc[2];
                wcnt = 0;
            end
            if (done) idx++;
        end
        // reset during a stall in the add's memory wait
        while (!(step[4] && wait_mfc)) begin
            @(negedge clk);
            if (step[2]) opcode = 4'b0001;
            mfc = wait_mfc ? 1'b1 : 1'b0;
            if (step[4]) mfc = 1'b0;
        end
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mfc = 1'b1;
        repeat (4) @(negedge clk);
        #(CLK_PERIOD/2);
        wrap_up();
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        wrap_up();
    end

endmodule